// File: doc/BRIEF.md
# Keyed Manual Channel Pulse Trigger

This block is a write-only command register that lets software fire a single trigger on one of six output channels, but only after a fixed four-byte unlock key has been written to it. Every write to the register shows up as a one-cycle write strobe with an 8-bit data byte. An internal matcher follows the key one byte at a time. Once the whole key has arrived, the next write is read as a channel number.

If that channel number is between 1 and 6, the block raises the matching bit of a six-bit one-hot trigger vector for exactly one clock. Any write that breaks the key sends the matcher back to the start. Each trigger uses up the key, so a stray write or a runaway loop of writes cannot fire a channel by accident. The register has no read path. Shaping and driving the pulse happen downstream.

Top module: `pulseKeyTrigger`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `trigOut` to zero in the following cycle and returns the matcher to idle. Key bytes written before the reset do not count afterwards.
- R2: The key is the write sequence 0xDE, 0xAD, 0xBE, 0xEF. If the next write after it carries a value n from 1 to 6, `trigOut` bit n-1 is high in the cycle right after that write's clock edge, and only in that cycle.
- R3: Key bytes written in any order other than 0xDE, 0xAD, 0xBE, 0xEF do not arm the matcher, and the write that follows them triggers nothing.
- R4: A write that does not match the next expected key byte returns the matcher to idle. If that write is 0xDE, it counts as the first key byte of a new attempt.
- R5: After a complete key, a write of 0 or of any value from 7 to 255 triggers nothing and returns the matcher to idle.
- R6: After a trigger the matcher is idle, so a second channel write with no new key triggers nothing.
- R7: Cycles with `wrEn` low leave the matcher unchanged, whatever `wrData` holds, and never raise `trigOut`. Key writes may be separated by such idle cycles.
- R8: `trigOut` never has more than one bit set, and it is zero in any cycle that does not follow a valid channel write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe, one write per cycle when high |
| wrData | input | 8 | Write data byte |
| trigOut | output | 6 | One-hot channel trigger, bit n-1 selects channel n |

## Verification
Only one result can arrive at the ports, and that is a trigger bit, which is registered once. It is therefore due in the cycle after the clock edge that captures the channel write. Key-byte writes produce no visible result; their effect only shows when a later channel write does or does not fire. The bench drives inputs at the falling edge and compares `trigOut` at the next falling edge against the value its own reference model predicted for the write just made. Every comparison thus falls exactly one edge after its stimulus, and cycles with no write are also checked, with an expected value of zero.

// File: rtl/pulseKeyPkg.sv
package pulseKeyPkg;
  localparam int DATA_W   = 8;
  localparam int CHAN_NUM = 6;
  localparam int KEY_LEN  = 4;
  localparam int IDX_W    = $clog2(KEY_LEN);
  localparam int CNT_W    = $clog2(KEY_LEN + 1);

  // Unlock key bytes, in the order they must be written
  function automatic logic [DATA_W-1:0] keyByte(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    keyByte = 8'hDE;
      2'd1:    keyByte = 8'hAD;
      2'd2:    keyByte = 8'hBE;
      default: keyByte = 8'hEF;
    endcase
  endfunction

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             fireEn;  // channel write seen while armed
    logic             flush;   // clear the trigger register
    logic [IDX_W-1:0] keyIdx;  // which key byte is expected next
  } ctrlStrobe_t;
endpackage

// File: rtl/keyMatchCtrl.sv
module keyMatchCtrl
  import pulseKeyPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        keyHit,
  input  logic        restartHit,
  output ctrlStrobe_t strobe
);
  localparam logic [CNT_W-1:0] ARMED = CNT_W'(KEY_LEN);

  logic [CNT_W-1:0] keyCount;
  logic             armed;

  assign armed = (keyCount == ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      keyCount <= '0;
    end else if (wrEn) begin
      if (armed)           keyCount <= '0;
      else if (keyHit)     keyCount <= keyCount + 1'b1;
      else if (restartHit) keyCount <= CNT_W'(1);
      else                 keyCount <= '0;
    end
  end

  always_comb begin
    strobe.fireEn = armed && wrEn && !rst;
    strobe.flush  = rst;
    strobe.keyIdx = keyCount[IDX_W-1:0];
  end
endmodule

// File: rtl/trigDatapath.sv
module trigDatapath
  import pulseKeyPkg::*;
(
  input  logic              clk,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobe_t       strobe,
  output logic              keyHit,
  output logic              restartHit,
  output logic [CHAN_NUM-1:0] trigOut
);
  logic [CHAN_NUM-1:0] chanHit;

  assign keyHit     = (wrData == keyByte(strobe.keyIdx));
  assign restartHit = (wrData == keyByte('0));

  // One decoder per channel: channel n matches data value n
  for (genvar g = 0; g < CHAN_NUM; g++) begin : g_chan
    assign chanHit[g] = (wrData == DATA_W'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (strobe.flush)       trigOut <= '0;
    else if (strobe.fireEn) trigOut <= chanHit;
    else                    trigOut <= '0;
  end
endmodule

// File: rtl/pulseKeyTrigger.sv
module pulseKeyTrigger
  import pulseKeyPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [5:0]  trigOut
);
  ctrlStrobe_t strobe;
  logic        keyHit;
  logic        restartHit;

  keyMatchCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .keyHit     (keyHit),
    .restartHit (restartHit),
    .strobe     (strobe)
  );

  trigDatapath u_dp (
    .clk        (clk),
    .wrData     (wrData),
    .strobe     (strobe),
    .keyHit     (keyHit),
    .restartHit (restartHit),
    .trigOut    (trigOut)
  );
endmodule

// File: rtl/pulseKeyTrigger_chk.sv
module pulseKeyTrigger_chk (
  input logic       clk,
  input logic       rst,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [5:0] trigOut
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> trigOut == 6'd0);

  // R8
  one_hot_chk: assert property (@(posedge clk) disable iff (rst) $countones(trigOut) <= 1);

  // R7
  no_write_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> trigOut == 6'd0);

  // R2
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    trigOut != 6'd0 |=> trigOut == 6'd0);

  // R2
  channel_match_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrData == 8'd0 || wrData > 8'd6)) |=> trigOut == 6'd0);
endmodule

bind pulseKeyTrigger pulseKeyTrigger_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .trigOut (trigOut)
);

// File: tb/pulseKeyTrigger_bench.sv
module pulseKeyTrigger_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [5:0] trigOut;

  int    nTests = 0;
  int    nFail  = 0;
  int    mState = 0;
  logic [5:0] expVec = 6'd0;
  string prevTag = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  pulseKeyTrigger u_pulseKeyTrigger (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .trigOut(trigOut)
  );

  function automatic logic [7:0] refKey(input int i);
    case (i)
      0: return 8'hDE;
      1: return 8'hAD;
      2: return 8'hBE;
      default: return 8'hEF;
    endcase
  endfunction

  // Reference model step: returns the trigger expected after this cycle's edge
  function automatic logic [5:0] modelStep(input logic r, input logic en, input logic [7:0] d);
    logic [5:0] v = 6'd0;
    if (r) begin
      mState = 0;
    end else if (en) begin
      if (mState == 4) begin
        if (d >= 8'd1 && d <= 8'd6) v = 6'd1 << (d - 8'd1);
        mState = 0;
      end else if (d == refKey(mState)) mState = mState + 1;
      else if (d == 8'hDE) mState = 1;
      else mState = 0;
    end
    return v;
  endfunction

  task automatic cyc(input logic r, input logic en, input logic [7:0] d, input string tag);
    @(negedge clk);
    nTests++;
    if (trigOut !== expVec) begin
      nFail++;
      $display("FAIL %s: trigOut actual %b expected %b", prevTag, trigOut, expVec);
    end
    nTests++;
    if ($countones(trigOut) > 1) begin
      nFail++;
      $display("FAIL R8: trigOut actual %b expected at most one bit", trigOut);
    end
    rst = r; wrEn = en; wrData = d;
    expVec = modelStep(r, en, d);
    prevTag = tag;
  endtask

  task automatic sendKey(input string tag);
    cyc(0, 1, 8'hDE, tag); cyc(0, 1, 8'hAD, tag);
    cyc(0, 1, 8'hBE, tag); cyc(0, 1, 8'hEF, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    cyc(1, 0, 8'h00, "R1"); cyc(1, 1, 8'hDE, "R1"); cyc(0, 0, 8'h00, "R1");
    // R2: every channel
    for (int n = 1; n <= 6; n++) begin
      sendKey("R2"); cyc(0, 1, 8'(n), "R2"); cyc(0, 0, 8'h00, "R2");
    end
    // R3: wrong order
    cyc(0, 1, 8'hDE, "R3"); cyc(0, 1, 8'hBE, "R3"); cyc(0, 1, 8'hAD, "R3");
    cyc(0, 1, 8'hEF, "R3"); cyc(0, 1, 8'h02, "R3"); cyc(0, 0, 8'h00, "R3");
    // R4: break, then 0xDE restarts
    cyc(0, 1, 8'hDE, "R4"); cyc(0, 1, 8'hAD, "R4"); cyc(0, 1, 8'h11, "R4");
    cyc(0, 1, 8'hDE, "R4"); sendKey("R4"); cyc(0, 1, 8'h04, "R4");
    cyc(0, 1, 8'hDE, "R4"); cyc(0, 1, 8'hAD, "R4"); cyc(0, 1, 8'hBE, "R4");
    cyc(0, 1, 8'hDE, "R4"); cyc(0, 1, 8'hAD, "R4"); cyc(0, 1, 8'hBE, "R4");
    cyc(0, 1, 8'hEF, "R4"); cyc(0, 1, 8'h06, "R4");
    // R5: out-of-range channel, then plain channel must not fire
    sendKey("R5"); cyc(0, 1, 8'h00, "R5"); cyc(0, 1, 8'h03, "R5");
    sendKey("R5"); cyc(0, 1, 8'h07, "R5"); cyc(0, 1, 8'h01, "R5");
    sendKey("R5"); cyc(0, 1, 8'hFF, "R5"); cyc(0, 1, 8'h02, "R5");
    // R6: repeat without key
    sendKey("R6"); cyc(0, 1, 8'h05, "R6"); cyc(0, 1, 8'h05, "R6"); cyc(0, 0, 8'h00, "R6");
    // R7: gaps with garbage data while strobe low
    cyc(0, 1, 8'hDE, "R7"); cyc(0, 0, 8'h13, "R7"); cyc(0, 1, 8'hAD, "R7");
    cyc(0, 0, 8'hEF, "R7"); cyc(0, 0, 8'h02, "R7"); cyc(0, 1, 8'hBE, "R7");
    cyc(0, 1, 8'hEF, "R7"); cyc(0, 0, 8'h04, "R7"); cyc(0, 1, 8'h01, "R7");
    // R1: reset in the middle of a key
    cyc(0, 1, 8'hDE, "R1"); cyc(0, 1, 8'hAD, "R1"); cyc(1, 0, 8'h00, "R1");
    cyc(0, 1, 8'hBE, "R1"); cyc(0, 1, 8'hEF, "R1"); cyc(0, 1, 8'h01, "R1");
    // Random mix (R2 R4 R5 R7 R8)
    for (int i = 0; i < 3000; i++) begin
      logic       en = ($urandom % 4) != 0;
      logic [7:0] d;
      int         sel = $urandom % 8;
      if (mState < 4 && sel < 5) d = refKey(mState);
      else if (sel == 5) d = 8'hDE;
      else if (sel == 6) d = 8'($urandom % 8);
      else d = 8'($urandom);
      cyc(($urandom % 200) == 0, en, d, "R2");
    end
    cyc(0, 0, 8'h00, "R8");
    cyc(0, 0, 8'h00, "R8");
    finishRun();
  end
endmodule